// File: doc/BRIEF.md
# Serial DMA Request Encoder

This block sits on the peripheral side of a low-pin-count host bus and tells the host which DMA channels want service. Internal DMA agents each present a request level, one bit per channel. Whenever a channel's level changes, the block sends one serial message on a single active-low request line. The line is clocked by the bus clock.

A message is five bit-times long. It starts with a low start bit. The three-bit channel number follows, most significant bit first. The last bit is the activity flag: high means the channel now requests service, low means an earlier request for that channel is being withdrawn. After the activity flag the line returns high for at least one clock.

Changes are recorded per channel in a pending register. They are serviced lowest channel number first, so several channels can be outstanding at once and no arbitration is needed outside the block. When more changes are waiting, messages follow each other with exactly one idle clock between them.

Top module: `dma_req_serializer`

## Requirements
- R1: `serial_req_no` is high while reset is asserted and while no message is being sent. Reset also discards every recorded change, so no message follows reset unless a level differs from the low reset state.
- R2: A message begins with exactly one low start bit, driven on a clock where the line was high in the previous clock.
- R3: The three clocks after the start bit carry the channel number, most significant bit first (line high = 1).
- R4: The clock after the channel number carries the activity flag. It is the channel's registered level when the message is loaded: 1 means active, 0 means withdrawn.
- R5: After the activity flag the line is high for at least one clock. When another change is already pending, the next start bit follows after exactly one high clock.
- R6: Each clock in which a channel's input level differs from its last sampled level records one change for that channel. A channel with no recorded change produces no message.
- R7: When several channels hold recorded changes, messages go out in ascending channel order (channel 0 first).
- R8: A change that arrives on a channel while a message is being sent, including on the channel being sent, is kept and produces its own follow-up message. The message in flight is not disturbed.
- R9: From idle, a change sampled at clock edge k produces the start bit on the line after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_lvl_i | input | NUM_CH | Per-channel DMA request levels from the internal agents |
| serial_req_no | output | 1 | Serial request line, active low, idles high |

## Verification
Checked on every cycle:
- The line stays high whenever the encoder is idle with nothing pending.
- An idle encoder with a pending change drives the start bit on the next clock.
- Every activity flag is followed by a high clock.
- Every input level change is captured in the pending register.

Shown only by the bench's scenarios, through a decoding monitor and an ordered queue of expected messages:
- Correct channel numbers and activity flags.
- Ascending service order when several channels change.
- The exact single-clock gap between back-to-back messages.
- Follow-up messages for changes made mid-message.
- The two-edge start latency.
- Silence after reset.

// File: rtl/dreq_ser_pkg.sv
package dreq_ser_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } ser_state_e;
endpackage

// File: rtl/dreq_change_tracker.sv
module dreq_change_tracker #(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] lvl_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] lvl_o,
  output logic [NUM_CH-1:0] pend_o
);
  logic [NUM_CH-1:0] lvl_q, pend_q;

  // a new edge on a channel wins over the clear of that channel
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      pend_q <= '0;
    end else begin
      lvl_q  <= lvl_i;
      pend_q <= (pend_q & ~clr_i) | (lvl_i ^ lvl_q);
    end
  end

  assign lvl_o  = lvl_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/dreq_prio_pick.sv
module dreq_prio_pick #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic [NUM_CH-1:0] pend_i,
  output logic              any_o,
  output logic [CH_W-1:0]   idx_o,
  output logic [NUM_CH-1:0] gnt_o
);
  // scan high to low so the lowest set bit is the last one written
  always_comb begin
    idx_o = '0;
    gnt_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        idx_o    = CH_W'(i);
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
      end
    end
  end

  assign any_o = |pend_i;
endmodule

// File: rtl/dreq_frame_shifter.sv
module dreq_frame_shifter
  import dreq_ser_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              any_i,
  input  logic [CH_W-1:0]   idx_i,
  input  logic [NUM_CH-1:0] lvl_i,
  output logic              load_o,
  output logic              idle_o,
  output logic              line_o
);
  localparam int FRAME_W = CH_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  ser_state_e         st_q;
  logic [FRAME_W-1:0] data_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               line_q;

  assign idle_o = (st_q == ST_IDLE);
  assign load_o = idle_o && any_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      data_q <= '0;
      cnt_q  <= '0;
      line_q <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (any_i) begin
            line_q <= 1'b0;
            data_q <= {idx_i, lvl_i[idx_i]};
            cnt_q  <= CNT_W'(FRAME_W);
            st_q   <= ST_SEND;
          end
        end
        ST_SEND: begin
          line_q <= data_q[FRAME_W-1];
          data_q <= {data_q[FRAME_W-2:0], 1'b0};
          cnt_q  <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) st_q <= ST_GAP;
        end
        ST_GAP: begin
          line_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/dma_req_serializer.sv
module dma_req_serializer #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_lvl_i,
  output logic              serial_req_no
);
  logic [NUM_CH-1:0] lvl_w, pend_w, gnt_w, clr_w;
  logic [CH_W-1:0]   idx_w;
  logic              any_w, load_w, idle_w;

  assign clr_w = gnt_w & {NUM_CH{load_w}};

  dreq_change_tracker #(.NUM_CH(NUM_CH)) u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (req_lvl_i),
    .clr_i  (clr_w),
    .lvl_o  (lvl_w),
    .pend_o (pend_w)
  );

  dreq_prio_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
    .pend_i (pend_w),
    .any_o  (any_w),
    .idx_o  (idx_w),
    .gnt_o  (gnt_w)
  );

  dreq_frame_shifter #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .any_i  (any_w),
    .idx_i  (idx_w),
    .lvl_i  (lvl_w),
    .load_o (load_w),
    .idle_o (idle_w),
    .line_o (serial_req_no)
  );
endmodule

// File: rtl/dreq_ser_checker.sv
module dreq_ser_checker #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] req_lvl_i,
  input logic              serial_req_no,
  input logic [NUM_CH-1:0] lvl_q,
  input logic [NUM_CH-1:0] pend_q,
  input logic              idle
);
  localparam int FRAME_W = CH_W + 1;
  localparam int POS_W   = $clog2(FRAME_W + 2);

  // independent frame position tracker driven only by the line
  logic [POS_W-1:0] pos_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else if (pos_q == '0) begin
      if (!serial_req_no) pos_q <= POS_W'(1);
    end else if (pos_q == POS_W'(FRAME_W + 1)) pos_q <= '0;
    else pos_q <= pos_q + POS_W'(1);
  end

  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && pend_q == '0) |=> serial_req_no);

  p_start_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && pend_q != '0) |=> !serial_req_no);

  p_gap_after_act_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == POS_W'(FRAME_W + 1)) |-> serial_req_no);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cap
    p_change_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_lvl_i[i] != lvl_q[i]) |=> pend_q[i]);
  end
endmodule

bind dma_req_serializer dreq_ser_checker #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_lvl_i     (req_lvl_i),
  .serial_req_no (serial_req_no),
  .lvl_q         (lvl_w),
  .pend_q        (pend_w),
  .idle          (idle_w)
);

// File: tb/dma_req_serializer_test.sv
module dma_req_serializer_test;
  localparam int NUM_CH = 8;

  typedef struct {
    int    ch;
    int    act;
    bit    b2b;
    string tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NUM_CH-1:0] req_lvl = '0;
  logic              serial_req_no;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #4ns clk = ~clk;

  dma_req_serializer #(.NUM_CH(NUM_CH)) uut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .req_lvl_i     (req_lvl),
    .serial_req_no (serial_req_no)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input int ch, input int act, input bit b2b, input string tag);
    exp_t e;
    e.ch = ch; e.act = act; e.b2b = b2b; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic expect_quiet(input int n, input string tag);
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!serial_req_no) ok = 1'b0;
    end
    chk(ok, tag, ok ? 1 : 0, 1);
  endtask

  // monitor: decode frames from the line and compare against the queue
  initial begin
    int hi_cnt = 0;
    bit need_hi = 1'b0;
    logic [2:0] got_ch;
    logic got_act;
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst_ni) begin
        hi_cnt = 0; need_hi = 1'b0;
      end else if (serial_req_no) begin
        if (need_hi) begin chk(1'b1, "R5 high after act", 1, 1); need_hi = 1'b0; end
        hi_cnt++;
      end else begin
        if (need_hi) chk(1'b0, "R5 high after act", 0, 1);
        need_hi = 1'b0;
        got_ch = '0;
        for (int b = 0; b < 3; b++) begin
          @(negedge clk);
          got_ch = {got_ch[1:0], serial_req_no};
        end
        @(negedge clk);
        got_act = serial_req_no;
        if (q.size() == 0) begin
          chk(1'b0, "R6 unexpected message", int'(got_ch), -1);
        end else begin
          e = q.pop_front();
          chk(int'(got_ch) == e.ch, {e.tag, " R2 R3 channel"}, int'(got_ch), e.ch);
          chk(int'(got_act) == e.act, {e.tag, " R4 act"}, int'(got_act), e.act);
          if (e.b2b) chk(hi_cnt == 1, {e.tag, " R5 gap"}, hi_cnt, 1);
        end
        hi_cnt = 0;
        need_hi = 1'b1;
      end
    end
  end

  initial begin
    #(8ns * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NUM_CH-1:0] nxt;
    repeat (3) @(negedge clk);
    chk(serial_req_no == 1'b1, "R1 reset level", serial_req_no, 1);
    rst_ni = 1'b1;
    expect_quiet(10, "R1 idle after reset");

    // R9 latency and single rise/fall
    push(5, 1, 1'b0, "R9");
    req_lvl[5] = 1'b1;
    @(negedge clk);
    chk(serial_req_no == 1'b1, "R9 no start after first edge", serial_req_no, 1);
    @(negedge clk);
    chk(serial_req_no == 1'b0, "R9 start after second edge", serial_req_no, 0);
    drain();
    push(5, 0, 1'b0, "R4 withdraw");
    req_lvl[5] = 1'b0;
    drain();
    expect_quiet(12, "R6 no change no message");

    // R7 simultaneous changes go out lowest first
    push(1, 1, 1'b0, "R7");
    push(3, 1, 1'b1, "R7");
    push(6, 1, 1'b1, "R7");
    req_lvl[6] = 1'b1; req_lvl[1] = 1'b1; req_lvl[3] = 1'b1;
    drain();

    // R6 one-cycle pulse gives two messages
    push(4, 1, 1'b0, "R6 pulse");
    push(4, 0, 1'b1, "R6 pulse");
    req_lvl[4] = 1'b1;
    @(negedge clk);
    req_lvl[4] = 1'b0;
    drain();

    // R8 changes during a message
    push(2, 1, 1'b0, "R8");
    push(0, 1, 1'b1, "R8");
    push(2, 0, 1'b1, "R8");
    req_lvl[2] = 1'b1;
    while (serial_req_no) @(negedge clk);
    @(negedge clk);
    req_lvl[0] = 1'b1; req_lvl[2] = 1'b0;
    drain();

    // R7 all channels change at once
    nxt = ~req_lvl;
    for (int i = 0; i < NUM_CH; i++) push(i, int'(nxt[i]), i != 0, "R7 all");
    req_lvl = nxt;
    drain();

    // R1 reset discards recorded changes
    req_lvl = '0;
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(serial_req_no == 1'b1, "R1 line high in reset", serial_req_no, 1);
    rst_ni = 1'b1;
    expect_quiet(20, "R1 pending cleared by reset");

    chk(q.size() == 0, "R6 all expected messages seen", q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule